// File: doc/BRIEF.md
# DMA Channel Major-Loop Completion Controller

This block keeps the per-channel control and status bits of a multi-channel DMA engine and acts on them when a channel's outer iteration count runs out. Each channel holds a link-enable bit, a 6-bit link target channel number, a scatter/gather-enable bit, a disable-request bit and a 32-byte-aligned next-descriptor pointer. A small state machine per channel tracks whether the channel is idle, running or done.

The engine reports events for one channel at a time on a shared event port (`ev_ch`). When it reports that the count has reached zero, the block does three things in that same cycle. It can pulse the start bit of a linked channel. It can request a descriptor reload at the channel's pointer. It can pulse a clear of the channel's hardware request enable. Software configures channels through a write port and reads status back through a combinational read port.

The per-channel states are `CH_IDLE`, `CH_RUN` and `CH_DONE`. The transitions are checked in this priority order:
- `ERR_ABORT`: an error moves `CH_RUN` to `CH_IDLE`. The other states hold.
- `MAJOR_END`: a count-zero event moves any state to `CH_DONE`.
- `SVC_BEGIN`: a service start moves any state to `CH_RUN`.
- `MINOR_END`: the end of a minor loop moves `CH_RUN` to `CH_IDLE`.
- `SW_CLEAR`: a software done-clear moves `CH_DONE` to `CH_IDLE`.

Top module: `dmc_top`

## Requirements
- R1: After reset every channel reads done=0 and active=0, with all configuration fields and the pointer zero. No completion pulse is driven.
- R2: A service start on a channel sets active (status bit 9) and clears done (status bit 10) from the next cycle on.
- R3: A minor-loop-complete event or an error event on a running channel clears active from the next cycle on, and done stays 0.
- R4: A count-zero event without an error sets done and clears active from the next cycle on.
- R5: On a count-zero event with link-enable set and a target below NUM_CH, `start_set` has exactly the target's bit set in that same cycle. The pulse lasts one cycle.
- R6: On a count-zero event with link-enable set and a target of NUM_CH or more, `start_set` stays zero and `link_err` pulses.
- R7: On a count-zero event with scatter/gather-enable set and a pointer whose low 5 bits are zero, `fetch_req` pulses with `fetch_addr` equal to the pointer and `fetch_ch` equal to the channel. If any of the low 5 bits is nonzero, `sg_err` pulses and there is no fetch.
- R8: On a count-zero event, `erq_clr` has the channel's bit set only if disable-request is set. Otherwise it stays zero.
- R9: A control write (wr_sel=0) is laid out as: bit0 clears done, bit1 link-enable, bit2 scatter/gather-enable, bit3 disable-request, bits 9:4 target. If done is 1 when the write lands, link-enable and scatter/gather-enable store 0 and the other fields store the written values.
- R10: If a software done-clear and a count-zero event on the same channel fall in the same cycle, done reads 1 afterwards.
- R11: A control write with bit0=1 clears done. A control write with bit0=0 leaves done unchanged.
- R12: An error in the same cycle as a count-zero event suppresses every completion pulse and leaves done at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = descriptor pointer |
| wr_ch | input | CH_W | Channel written |
| wr_data | input | ADDR_W | Write data |
| rd_ch | input | CH_W | Channel read back |
| rd_status | output | 11 | {done, active, dis_req, sg_en, link_en, target[5:0]} |
| rd_ptr | output | ADDR_W | Descriptor pointer of rd_ch |
| ev_start | input | 1 | Service of ev_ch begins |
| ev_minor_done | input | 1 | Minor loop of ev_ch complete |
| ev_major_zero | input | 1 | Major count of ev_ch reached zero |
| ev_error | input | 1 | Error detected on ev_ch |
| ev_ch | input | CH_W | Channel the events refer to |
| start_set | output | NUM_CH | Start-bit set pulses |
| erq_clr | output | NUM_CH | Request-enable clear pulses |
| fetch_req | output | 1 | Descriptor fetch request pulse |
| fetch_ch | output | CH_W | Channel to reload |
| fetch_addr | output | ADDR_W | Descriptor fetch address |
| link_err | output | 1 | Link target out of range |
| sg_err | output | 1 | Misaligned descriptor pointer |

## Verification
A channel stuck in the wrong state shows at the read port one cycle after the event that should have moved it. For example, done stays set after a service start, or active survives a minor-loop end. A wrong configuration field shows in the same cycle as the next count-zero strobe: the wrong start bit or request-clear bit pulses, or a fetch goes out instead of an error. The bench therefore reads each channel's status right after every event and samples the pulses while the count-zero strobe is held.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic       dis_req;
        logic       sg_en;
        logic       link_en;
        logic [5:0] tgt;
    } ch_cfg_t;

    localparam int CW_CLR  = 0;
    localparam int CW_LINK = 1;
    localparam int CW_SG   = 2;
    localparam int CW_DIS  = 3;
    localparam int CW_TGT  = 4;
    localparam int STAT_W  = 11;
endpackage

// File: rtl/dmc_chan.sv
module dmc_chan
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_minor,
    input  logic              ev_major,
    input  logic              ev_err,
    input  logic              wr_ctrl,
    input  logic              wr_ptr,
    input  logic [ADDR_W-1:0] wr_data,
    output ch_cfg_t           cfg,
    output logic [ADDR_W-1:0] ptr,
    output logic              done,
    output logic              active
);
    ch_state_e state_q, state_d;
    logic      sw_clr;

    assign sw_clr = wr_ctrl && wr_data[CW_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ev_err) begin
            if (state_q == CH_RUN) state_d = CH_IDLE;
        end else if (ev_major) begin
            state_d = CH_DONE;
        end else if (ev_start) begin
            state_d = CH_RUN;
        end else begin
            unique case (state_q)
                CH_RUN:  if (ev_minor) state_d = CH_IDLE;
                CH_DONE: if (sw_clr)   state_d = CH_IDLE;
                CH_IDLE: state_d = CH_IDLE;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_comb begin
        done   = (state_q == CH_DONE);
        active = (state_q == CH_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
            ptr <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.tgt     <= wr_data[CW_TGT +: 6];
                cfg.dis_req <= wr_data[CW_DIS];
                cfg.link_en <= wr_data[CW_LINK] && !done;
                cfg.sg_en   <= wr_data[CW_SG] && !done;
            end
            if (wr_ptr) ptr <= wr_data;
        end
    end
endmodule

// File: rtl/dmc_complete.sv
module dmc_complete
    import dmc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              ev_major,
    input  logic              ev_err,
    input  logic [CH_W-1:0]   ev_ch,
    input  ch_cfg_t           cfg,
    input  logic [ADDR_W-1:0] ptr,
    output logic [NUM_CH-1:0] start_set,
    output logic [NUM_CH-1:0] erq_clr,
    output logic              fetch_req,
    output logic [CH_W-1:0]   fetch_ch,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              link_err,
    output logic              sg_err
);
    localparam logic [6:0] NCH = 7'(NUM_CH);

    logic fire, tgt_ok, aligned;

    assign fire    = ev_major && !ev_err;
    assign tgt_ok  = {1'b0, cfg.tgt} < NCH;
    assign aligned = (ptr[4:0] == 5'd0);

    always_comb begin
        start_set  = '0;
        erq_clr    = '0;
        fetch_req  = 1'b0;
        link_err   = 1'b0;
        sg_err     = 1'b0;
        fetch_ch   = ev_ch;
        fetch_addr = ptr;
        if (fire) begin
            if (cfg.link_en) begin
                if (tgt_ok) start_set[cfg.tgt[CH_W-1:0]] = 1'b1;
                else        link_err = 1'b1;
            end
            if (cfg.sg_en) begin
                if (aligned) fetch_req = 1'b1;
                else         sg_err = 1'b1;
            end
            if (cfg.dis_req) erq_clr[ev_ch] = 1'b1;
        end
    end
endmodule

// File: rtl/dmc_top.sv
module dmc_top
    import dmc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [10:0]       rd_status,
    output logic [ADDR_W-1:0] rd_ptr,
    input  logic              ev_start,
    input  logic              ev_minor_done,
    input  logic              ev_major_zero,
    input  logic              ev_error,
    input  logic [CH_W-1:0]   ev_ch,
    output logic [NUM_CH-1:0] start_set,
    output logic [NUM_CH-1:0] erq_clr,
    output logic              fetch_req,
    output logic [CH_W-1:0]   fetch_ch,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              link_err,
    output logic              sg_err
);
    ch_cfg_t           cfg_a  [NUM_CH];
    logic [ADDR_W-1:0] ptr_a  [NUM_CH];
    logic [NUM_CH-1:0] done_a;
    logic [NUM_CH-1:0] act_a;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_ev, hit_wr;
        assign hit_ev = (ev_ch == CH_W'(c));
        assign hit_wr = wr_en && (wr_ch == CH_W'(c));
        dmc_chan #(.ADDR_W(ADDR_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_start (ev_start && hit_ev),
            .ev_minor (ev_minor_done && hit_ev),
            .ev_major (ev_major_zero && hit_ev),
            .ev_err   (ev_error && hit_ev),
            .wr_ctrl  (hit_wr && !wr_sel),
            .wr_ptr   (hit_wr && wr_sel),
            .wr_data  (wr_data),
            .cfg      (cfg_a[c]),
            .ptr      (ptr_a[c]),
            .done     (done_a[c]),
            .active   (act_a[c])
        );
    end

    always_comb begin
        rd_status = {done_a[rd_ch], act_a[rd_ch], cfg_a[rd_ch].dis_req,
                     cfg_a[rd_ch].sg_en, cfg_a[rd_ch].link_en, cfg_a[rd_ch].tgt};
        rd_ptr    = ptr_a[rd_ch];
    end

    dmc_complete #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_complete (
        .ev_major   (ev_major_zero),
        .ev_err     (ev_error),
        .ev_ch      (ev_ch),
        .cfg        (cfg_a[ev_ch]),
        .ptr        (ptr_a[ev_ch]),
        .start_set  (start_set),
        .erq_clr    (erq_clr),
        .fetch_req  (fetch_req),
        .fetch_ch   (fetch_ch),
        .fetch_addr (fetch_addr),
        .link_err   (link_err),
        .sg_err     (sg_err)
    );
endmodule

// File: rtl/dmc_top_chk.sv
module dmc_top_chk #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CH_W-1:0]   rd_ch,
    input logic [10:0]       rd_status,
    input logic              ev_start,
    input logic              ev_major_zero,
    input logic              ev_error,
    input logic [CH_W-1:0]   ev_ch,
    input logic [NUM_CH-1:0] start_set,
    input logic [NUM_CH-1:0] erq_clr,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              link_err,
    input logic              sg_err
);
    p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_set));

    p_start_needs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_set != '0) |-> (ev_major_zero && !ev_error));

    p_link_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> (start_set == '0));

    p_fetch_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr[4:0] == 5'd0 && !sg_err));

    p_erq_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(erq_clr));

    p_error_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_error |-> (start_set == '0 && erq_clr == '0 && !fetch_req && !link_err && !sg_err));

    p_done_after_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_major_zero && !ev_error) |=> (rd_ch != $past(ev_ch) || (rd_status[10] && !rd_status[9])));

    p_active_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_major_zero && !ev_error) |=>
            (rd_ch != $past(ev_ch) || (rd_status[9] && !rd_status[10])));
endmodule

bind dmc_top dmc_top_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_ch         (rd_ch),
    .rd_status     (rd_status),
    .ev_start      (ev_start),
    .ev_major_zero (ev_major_zero),
    .ev_error      (ev_error),
    .ev_ch         (ev_ch),
    .start_set     (start_set),
    .erq_clr       (erq_clr),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .link_err      (link_err),
    .sg_err        (sg_err)
);

// File: tb/dmc_top_bench.sv
module dmc_top_bench;
    localparam int NUM_CH = 8;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_sel = 0;
    logic [2:0]  wr_ch = 0, rd_ch = 0, ev_ch = 0;
    logic [31:0] wr_data = 0;
    logic [10:0] rd_status;
    logic [31:0] rd_ptr;
    logic        ev_start = 0, ev_minor_done = 0, ev_major_zero = 0, ev_error = 0;
    logic [7:0]  start_set, erq_clr;
    logic        fetch_req, link_err, sg_err;
    logic [2:0]  fetch_ch;
    logic [31:0] fetch_addr;

    logic [7:0]  c_start, c_erq;
    logic        c_fetch, c_lerr, c_serr;
    logic [2:0]  c_fch;
    logic [31:0] c_faddr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dmc_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dmc_top (.*);

    typedef struct packed {
        logic [2:0]  ch;
        logic [9:0]  ctrl;
        logic [31:0] ptr;
        logic [7:0]  e_start;
        logic        e_fetch;
        logic [7:0]  e_erq;
        logic        e_lerr;
        logic        e_serr;
    } vec_t;

    // ctrl: bit1 link, bit2 sg, bit3 disable-request, bits 9:4 target
    localparam vec_t VEC [8] = '{
        '{3'd1, 10'h032, 32'h0,         8'h08, 1'b0, 8'h00, 1'b0, 1'b0},
        '{3'd2, 10'h092, 32'h0,         8'h00, 1'b0, 8'h00, 1'b1, 1'b0},
        '{3'd3, 10'h004, 32'h1000_0040, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0},
        '{3'd4, 10'h004, 32'h0000_0044, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1},
        '{3'd5, 10'h008, 32'h0,         8'h00, 1'b0, 8'h20, 1'b0, 1'b0},
        '{3'd6, 10'h00E, 32'h0000_0080, 8'h01, 1'b1, 8'h40, 1'b0, 1'b0},
        '{3'd0, 10'h000, 32'h0000_0020, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
        '{3'd7, 10'h076, 32'h0000_0021, 8'h80, 1'b0, 8'h00, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic mn, input logic mz, input logic er, input logic [2:0] ch,
                       input logic we, input logic ws, input logic [2:0] wch, input logic [31:0] wd);
        ev_start = s; ev_minor_done = mn; ev_major_zero = mz; ev_error = er; ev_ch = ch;
        wr_en = we; wr_sel = ws; wr_ch = wch; wr_data = wd;
        #5;
        c_start = start_set; c_erq = erq_clr; c_fetch = fetch_req; c_fch = fetch_ch;
        c_faddr = fetch_addr; c_lerr = link_err; c_serr = sg_err;
        @(negedge clk);
        ev_start = 0; ev_minor_done = 0; ev_major_zero = 0; ev_error = 0;
        wr_en = 0; wr_sel = 0;
    endtask

    task automatic wctl(input logic [2:0] ch, input logic [31:0] d);
        cyc(0, 0, 0, 0, 3'd0, 1, 0, ch, d);
    endtask

    task automatic wptr(input logic [2:0] ch, input logic [31:0] d);
        cyc(0, 0, 0, 0, 3'd0, 1, 1, ch, d);
    endtask

    task automatic ev(input logic s, input logic mn, input logic mz, input logic er, input logic [2:0] ch);
        cyc(s, mn, mz, er, ch, 0, 0, 3'd0, 32'd0);
    endtask

    task automatic rd(input logic [2:0] ch, output logic [10:0] st);
        rd_ch = ch;
        #1;
        st = rd_status;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int c = 0; c < NUM_CH; c++) begin
            rd(3'(c), st);
            chk("R1", "status after reset", 32'(st), 32'h0);
            chk("R1", "pointer after reset", rd_ptr, 32'h0);
        end
        chk("R1", "no pulses after reset", {start_set, erq_clr, fetch_req, link_err, sg_err}, 0);

        // Table walk: R2, R4, R5, R6, R7, R8
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = VEC[i];
            wctl(v.ch, {22'd0, v.ctrl});
            wptr(v.ch, v.ptr);
            ev(1, 0, 0, 0, v.ch);
            rd(v.ch, st);
            chk("R2", "active after start", {30'd0, st[10:9]}, 32'h1);
            ev(0, 0, 1, 0, v.ch);
            chk("R5", "start_set on count zero", 32'(c_start), 32'(v.e_start));
            chk("R6", "link_err", 32'(c_lerr), 32'(v.e_lerr));
            chk("R7", "fetch_req", 32'(c_fetch), 32'(v.e_fetch));
            chk("R7", "sg_err", 32'(c_serr), 32'(v.e_serr));
            if (v.e_fetch) begin
                chk("R7", "fetch_addr", c_faddr, v.ptr);
                chk("R7", "fetch_ch", 32'(c_fch), 32'(v.ch));
            end
            chk("R8", "erq_clr", 32'(c_erq), 32'(v.e_erq));
            rd(v.ch, st);
            chk("R4", "done set active clear", {30'd0, st[10:9]}, 32'h2);
            ev(0, 0, 0, 0, 3'd0);
            chk("R5", "start_set one cycle", 32'(c_start), 32'h0);
            wctl(v.ch, 32'h1);
            rd(v.ch, st);
            chk("R11", "done cleared by write", 32'(st[10]), 32'h0);
        end

        // R3: minor-loop end and error clear active
        ev(1, 0, 0, 0, 3'd3);
        ev(0, 1, 0, 0, 3'd3);
        rd(3'd3, st);
        chk("R3", "minor end clears active", {30'd0, st[10:9]}, 32'h0);
        ev(1, 0, 0, 0, 3'd3);
        ev(0, 0, 0, 1, 3'd3);
        rd(3'd3, st);
        chk("R3", "error clears active", {30'd0, st[10:9]}, 32'h0);

        // R12: error and count zero together
        wctl(3'd4, 32'h01A);
        wptr(3'd4, 32'h0);
        ev(1, 0, 0, 0, 3'd4);
        ev(0, 0, 1, 1, 3'd4);
        chk("R12", "no pulses on error", {c_start, c_erq, c_fetch, c_lerr, c_serr}, 0);
        rd(3'd4, st);
        chk("R12", "done stays 0", {30'd0, st[10:9]}, 32'h0);

        // R9: write while done forces enables to zero
        wctl(3'd2, 32'h0);
        ev(1, 0, 0, 0, 3'd2);
        ev(0, 0, 1, 0, 3'd2);
        wctl(3'd2, 32'h05E);
        rd(3'd2, st);
        chk("R9", "enables forced to 0 while done", 32'(st), 32'h505);
        chk("R11", "bit0=0 keeps done", 32'(st[10]), 32'h1);

        // R10: software clear and hardware set in the same cycle
        cyc(0, 0, 1, 0, 3'd2, 1, 0, 3'd2, 32'h1);
        rd(3'd2, st);
        chk("R10", "hardware set wins", 32'(st[10]), 32'h1);

        // R2: start clears done
        ev(1, 0, 0, 0, 3'd2);
        rd(3'd2, st);
        chk("R2", "start clears done", {30'd0, st[10:9]}, 32'h1);
        ev(0, 1, 0, 0, 3'd2);

        // R9: write with done clear stores enables
        wctl(3'd2, 32'h05E);
        rd(3'd2, st);
        chk("R9", "enables stored when not done", 32'(st), 32'h1C5);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule